// File: doc/BRIEF.md
# Condition Register Update Unit

This block holds a 32-bit condition register split into eight 4-bit fields. Field 0 sits in the most significant nibble and field 7 in the least significant one. Several execution paths can request a write to the register. In any one cycle a fixed priority picks a single winner. The winner's new value is latched at the next rising clock edge.

The write paths are:

- a record-form update of field 0, derived from a signed comparison of a result against zero;
- a masked load of whole fields from a 32-bit general-purpose word;
- a copy from one field to another;
- a load of one field from the top four bits of the fixed-point exception register;
- a direct write of a precomputed compare code into a chosen field.

Branch logic reads the register through a narrow port that can reach fields 0 to 3 only. The whole register value is also visible on an output.

Inside a field, bit 3 is less-than (LT), bit 2 is greater-than (GT), bit 1 is equal (EQ) and bit 0 is summary-overflow (SO). Field k occupies `cr_value[31-4k : 28-4k]`.

Top module: `cr_update_unit`

## Requirements
- R1: When `rst_n` is low at a rising edge, the register becomes all zeros at that edge.
- R2: A record-form update (`rec_en`) writes field 0 as follows. Bits 31:29 are 100 for a negative result, 010 for a positive result and 001 for a zero result. Bit 28 is set to `xer_top[3]`, which is the exception register's SO bit.
- R3: When `mode64` is 1, the record-form comparison uses all 64 bits of `rec_res`. When `mode64` is 0, it uses only `rec_res[31:0]`, read as a signed 32-bit value.
- R4: When `rec_undef` is 1 during a record-form update, bits 31:29 are written as 000. Bit 28 still takes the SO bit.
- R5: A masked move (`mv_en`) copies `mv_word[4i+3:4i]` into `cr_value[4i+3:4i]` for every i where `mv_mask[i]` is 1. Mask bit 7 therefore selects field 0. Nibbles whose mask bit is 0 keep their value.
- R6: A field copy (`cp_en`) writes field `cp_dst` with the value field `cp_src` held before the edge. A copy of a field onto itself leaves the register unchanged.
- R7: An exception-register load (`xl_en`) writes `xer_top` into field `xl_dst`.
- R8: A compare write (`cmp_en`) writes `cmp_code` into field `cmp_dst`.
- R9: When several requests are active in the same cycle, only the highest-priority one takes effect. The order from highest to lowest is masked move, field copy, exception-register load, compare write, record-form update.
- R10: For `br_idx` from 0 to 3, the output `br_fld` shows that field and `br_err` is 0. For `br_idx` from 4 to 7, `br_err` is 1 and `br_fld` is 0000. Both outputs are combinational.
- R11: When no request is active, the register keeps its value. An accepted update appears on `cr_value` after the next rising edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mv_en | input | 1 | Masked move request |
| mv_mask | input | 8 | Nibble enable mask; bit i enables nibble i |
| mv_word | input | 32 | Source word for the masked move |
| cp_en | input | 1 | Field copy request |
| cp_src | input | 3 | Source field index for the copy |
| cp_dst | input | 3 | Destination field index for the copy |
| xl_en | input | 1 | Exception-register load request |
| xl_dst | input | 3 | Destination field for the exception-register load |
| xer_top | input | 4 | Exception register bits 32..35; bit 3 is SO |
| cmp_en | input | 1 | Compare write request |
| cmp_dst | input | 3 | Destination field for the compare code |
| cmp_code | input | 4 | Compare code to write |
| rec_en | input | 1 | Record-form update request for field 0 |
| rec_res | input | 64 | Result value to compare against zero |
| rec_undef | input | 1 | Result is undefined |
| mode64 | input | 1 | 1 selects 64-bit comparison, 0 selects 32-bit comparison |
| br_idx | input | 3 | Field index for the branch read port |
| br_fld | output | 4 | Selected field, or 0000 when the index is illegal |
| br_err | output | 1 | Index is outside fields 0 to 3 |
| cr_value | output | 32 | Full register contents |

## Verification
The hardest cases to reach are the mode-dependent comparisons, because the 64-bit and 32-bit signs must disagree. The bench drives results whose low word is zero or negative while the full 64-bit value is positive. It also drives results where only the upper half is nonzero. The same result is then applied in both modes, and the field-0 codes are checked to differ. Priority is tested by raising adjacent pairs of requests that target the same field with different data, so that only the expected winner's value can appear.

// File: rtl/cr_upd_pkg.sv
// Shared sizes and field access helpers for the condition register unit.
// Assumes field 0 is the most significant nibble.
package cr_upd_pkg;
    localparam int FLD_W = 4;
    localparam int NFLD  = 8;
    localparam int CR_W  = FLD_W * NFLD;
    localparam int IDX_W = $clog2(NFLD);

    typedef enum logic [2:0] {
        SRC_NONE, SRC_MOVE, SRC_COPY, SRC_XER, SRC_CMP, SRC_REC
    } upd_src_e;

    // Read field idx (big-endian numbering) from a register image.
    function automatic logic [FLD_W-1:0] fld_get(logic [CR_W-1:0] cr, logic [IDX_W-1:0] idx);
        return cr[CR_W-1-FLD_W*int'(idx) -: FLD_W];
    endfunction

    // Return a register image with field idx replaced by v.
    function automatic logic [CR_W-1:0] fld_put(logic [CR_W-1:0] cr, logic [IDX_W-1:0] idx,
                                                logic [FLD_W-1:0] v);
        logic [CR_W-1:0] r;
        r = cr;
        r[CR_W-1-FLD_W*int'(idx) -: FLD_W] = v;
        return r;
    endfunction
endpackage

// File: rtl/cr_rec_eval.sv
// Builds the field-0 nibble for a record-form update: a sign/zero code in
// bits 3:1 and the SO bit in bit 0. Purely combinational; assumes RES_W is even.
module cr_rec_eval
    import cr_upd_pkg::*;
#(
    parameter int RES_W = 64
) (
    input  logic [RES_W-1:0] res,
    input  logic             mode64,
    input  logic             undef,
    input  logic             so,
    output logic [FLD_W-1:0] nib
);
    localparam int HALF = RES_W / 2;

    logic neg, zero;

    // Select sign and zero detection according to the comparison width.
    always_comb begin
        if (mode64) begin
            neg  = res[RES_W-1];
            zero = (res == '0);
        end else begin
            neg  = res[HALF-1];
            zero = (res[HALF-1:0] == '0);
        end
    end

    // Encode LT/GT/EQ and append SO; an undefined result clears the code.
    always_comb begin
        if (undef)     nib = {3'b000, so};
        else if (neg)  nib = {3'b100, so};
        else if (zero) nib = {3'b001, so};
        else           nib = {3'b010, so};
    end
endmodule

// File: rtl/cr_next_sel.sv
// Computes the next register image from the current value and the update
// requests, using a fixed priority. Assumes one winner per cycle.
module cr_next_sel
    import cr_upd_pkg::*;
(
    input  logic [CR_W-1:0]  cr_q,
    input  logic             mv_en,
    input  logic [NFLD-1:0]  mv_mask,
    input  logic [CR_W-1:0]  mv_word,
    input  logic             cp_en,
    input  logic [IDX_W-1:0] cp_src,
    input  logic [IDX_W-1:0] cp_dst,
    input  logic             xl_en,
    input  logic [IDX_W-1:0] xl_dst,
    input  logic [FLD_W-1:0] xer_top,
    input  logic             cmp_en,
    input  logic [IDX_W-1:0] cmp_dst,
    input  logic [FLD_W-1:0] cmp_code,
    input  logic             rec_en,
    input  logic [FLD_W-1:0] rec_nib,
    output upd_src_e         src,
    output logic [CR_W-1:0]  cr_d
);
    logic [CR_W-1:0] moved;

    // Per-nibble merge of the masked move.
    for (genvar i = 0; i < NFLD; i++) begin : g_mv
        assign moved[FLD_W*i +: FLD_W] = mv_mask[i] ? mv_word[FLD_W*i +: FLD_W]
                                                    : cr_q[FLD_W*i +: FLD_W];
    end

    // Fixed-priority arbitration among write sources.
    always_comb begin
        if (mv_en)       src = SRC_MOVE;
        else if (cp_en)  src = SRC_COPY;
        else if (xl_en)  src = SRC_XER;
        else if (cmp_en) src = SRC_CMP;
        else if (rec_en) src = SRC_REC;
        else             src = SRC_NONE;
    end

    // Form the next image from the winning source.
    always_comb begin
        unique case (src)
            SRC_MOVE: cr_d = moved;
            SRC_COPY: cr_d = fld_put(cr_q, cp_dst, fld_get(cr_q, cp_src));
            SRC_XER:  cr_d = fld_put(cr_q, xl_dst, xer_top);
            SRC_CMP:  cr_d = fld_put(cr_q, cmp_dst, cmp_code);
            SRC_REC:  cr_d = fld_put(cr_q, '0, rec_nib);
            default:  cr_d = cr_q;
        endcase
    end
endmodule

// File: rtl/cr_branch_port.sv
// Branch-side read port: exposes fields 0..BR_FLDS-1 and flags any other
// index as illegal, returning zero for it. Combinational.
module cr_branch_port
    import cr_upd_pkg::*;
#(
    parameter int BR_FLDS = 4
) (
    input  logic [CR_W-1:0]  cr,
    input  logic [IDX_W-1:0] idx,
    output logic [FLD_W-1:0] fld,
    output logic             err
);
    // Range-check the index and gate the read data.
    always_comb begin
        err = (int'(idx) >= BR_FLDS);
        fld = err ? '0 : fld_get(cr, idx);
    end
endmodule

// File: rtl/cr_update_unit.sv
// Condition register with prioritized write sources and read ports.
// Synchronous active-low reset; updates land on the next rising edge.
module cr_update_unit
    import cr_upd_pkg::*;
#(
    parameter int RES_W   = 64,
    parameter int BR_FLDS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mv_en,
    input  logic [NFLD-1:0]  mv_mask,
    input  logic [CR_W-1:0]  mv_word,
    input  logic             cp_en,
    input  logic [IDX_W-1:0] cp_src,
    input  logic [IDX_W-1:0] cp_dst,
    input  logic             xl_en,
    input  logic [IDX_W-1:0] xl_dst,
    input  logic [FLD_W-1:0] xer_top,
    input  logic             cmp_en,
    input  logic [IDX_W-1:0] cmp_dst,
    input  logic [FLD_W-1:0] cmp_code,
    input  logic             rec_en,
    input  logic [RES_W-1:0] rec_res,
    input  logic             rec_undef,
    input  logic             mode64,
    input  logic [IDX_W-1:0] br_idx,
    output logic [FLD_W-1:0] br_fld,
    output logic             br_err,
    output logic [CR_W-1:0]  cr_value
);
    logic [CR_W-1:0]  cr_q, cr_d;
    logic [FLD_W-1:0] rec_nib;
    upd_src_e         src;

    cr_rec_eval #(.RES_W(RES_W)) i_rec (
        .res(rec_res), .mode64(mode64), .undef(rec_undef),
        .so(xer_top[FLD_W-1]), .nib(rec_nib)
    );

    cr_next_sel i_sel (
        .cr_q(cr_q), .mv_en(mv_en), .mv_mask(mv_mask), .mv_word(mv_word),
        .cp_en(cp_en), .cp_src(cp_src), .cp_dst(cp_dst),
        .xl_en(xl_en), .xl_dst(xl_dst), .xer_top(xer_top),
        .cmp_en(cmp_en), .cmp_dst(cmp_dst), .cmp_code(cmp_code),
        .rec_en(rec_en), .rec_nib(rec_nib), .src(src), .cr_d(cr_d)
    );

    cr_branch_port #(.BR_FLDS(BR_FLDS)) i_br (
        .cr(cr_q), .idx(br_idx), .fld(br_fld), .err(br_err)
    );

    // Register state with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign cr_value = cr_q;

    logic [FLD_W-1:0] cp_src_val;
    assign cp_src_val = fld_get(cr_q, cp_src);

    // R1
    reset_zero_chk: assert property (@(posedge clk) !rst_n |=> cr_q == '0);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mv_en || cp_en || xl_en || cmp_en || rec_en) |=> $stable(cr_q));

    // R5
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_en && !mv_mask[NFLD-1] |=> cr_q[CR_W-1 -: FLD_W] == $past(cr_q[CR_W-1 -: FLD_W]));

    // R6
    copy_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en && !mv_en |=> fld_get(cr_q, $past(cp_dst)) == $past(cp_src_val));

    // R2
    rec_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en && !(mv_en || cp_en || xl_en || cmp_en) && !rec_undef && mode64 && rec_res[RES_W-1]
        |=> cr_q[CR_W-1 -: FLD_W] == {3'b100, $past(xer_top[FLD_W-1])});

    // R10
    br_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_err |-> br_fld == '0);
endmodule

// File: tb/test_cr_update_unit.sv
module test_cr_update_unit;
    logic        clk = 0, rst_n = 0;
    logic        mv_en = 0, cp_en = 0, xl_en = 0, cmp_en = 0, rec_en = 0;
    logic [7:0]  mv_mask = 0;
    logic [31:0] mv_word = 0;
    logic [2:0]  cp_src = 0, cp_dst = 0, xl_dst = 0, cmp_dst = 0, br_idx = 0;
    logic [3:0]  xer_top = 0, cmp_code = 0, br_fld;
    logic [63:0] rec_res = 0;
    logic        rec_undef = 0, mode64 = 1, br_err;
    logic [31:0] cr_value, exp_cr;
    int total = 0, bad = 0;
    bit done = 0;

    cr_update_unit i_cr_update_unit (
        .clk, .rst_n, .mv_en, .mv_mask, .mv_word, .cp_en, .cp_src, .cp_dst,
        .xl_en, .xl_dst, .xer_top, .cmp_en, .cmp_dst, .cmp_code, .rec_en,
        .rec_res, .rec_undef, .mode64, .br_idx, .br_fld, .br_err, .cr_value
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] put(logic [31:0] cr, int k, logic [3:0] v);
        logic [31:0] r;
        r = cr;
        r[31-4*k -: 4] = v;
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        mv_en = 0; cp_en = 0; xl_en = 0; cmp_en = 0; rec_en = 0; rec_undef = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; tick(); tick(); rst_n = 1;
        check("R1 reset", cr_value, 32'h0);
        exp_cr = 0;
    endtask

    task automatic rec(logic [63:0] r, logic m, logic u, logic [3:0] x, logic [3:0] f0, string tag);
        rec_en = 1; rec_res = r; mode64 = m; rec_undef = u; xer_top = x;
        check({tag, " pre-edge"}, cr_value, exp_cr);
        tick();
        exp_cr = put(exp_cr, 0, f0);
        check(tag, cr_value, exp_cr);
    endtask

    task automatic t_record();
        rec(64'hFFFF_FFFF_FFFF_FFF0, 1, 0, 4'h0, 4'b1000, "R2 neg");
        rec(64'h0000_0000_0000_0005, 1, 0, 4'h8, 4'b0101, "R2 pos so");
        rec(64'h0, 1, 0, 4'h8, 4'b0011, "R2 zero so");
        rec(64'h0000_0001_0000_0000, 1, 0, 4'h0, 4'b0100, "R3 64 pos");
        rec(64'h0000_0001_0000_0000, 0, 0, 4'h0, 4'b0010, "R3 32 zero");
        rec(64'h0000_0000_8000_0000, 0, 0, 4'h0, 4'b1000, "R3 32 neg");
        rec(64'h0000_0000_8000_0000, 1, 0, 4'h0, 4'b0100, "R3 64 pos2");
        rec(64'hFFFF_FFFF_0000_0007, 0, 0, 4'h0, 4'b0100, "R3 32 pos");
        rec(64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 4'h8, 4'b0001, "R4 undef");
    endtask

    task automatic t_move();
        mv_en = 1; mv_mask = 8'hA5; mv_word = 32'h1234_5678; tick();
        exp_cr = (exp_cr & ~32'hF0F0_0F0F) | (32'h1234_5678 & 32'hF0F0_0F0F);
        check("R5 mask A5", cr_value, exp_cr);
        mv_en = 1; mv_mask = 8'h00; mv_word = 32'hFFFF_FFFF; tick();
        check("R5 mask 0", cr_value, exp_cr);
        mv_en = 1; mv_mask = 8'hFF; mv_word = 32'h9ABC_DEF0; tick();
        exp_cr = 32'h9ABC_DEF0;
        check("R5 mask FF", cr_value, exp_cr);
    endtask

    task automatic t_copy();
        cp_en = 1; cp_src = 0; cp_dst = 5; tick();
        exp_cr = put(exp_cr, 5, exp_cr[31:28]);
        check("R6 copy 0->5", cr_value, exp_cr);
        cp_en = 1; cp_src = 3; cp_dst = 3; tick();
        check("R6 self copy", cr_value, exp_cr);
    endtask

    task automatic t_xer_cmp();
        xl_en = 1; xl_dst = 7; xer_top = 4'hB; tick();
        exp_cr = put(exp_cr, 7, 4'hB);
        check("R7 xer load", cr_value, exp_cr);
        cmp_en = 1; cmp_dst = 3; cmp_code = 4'b0100; tick();
        exp_cr = put(exp_cr, 3, 4'b0100);
        check("R8 cmp write", cr_value, exp_cr);
    endtask

    task automatic t_prio();
        exp_cr = 32'h0;
        mv_en = 1; mv_mask = 8'hFF; mv_word = 32'h0; tick();
        check("R9 setup", cr_value, exp_cr);
        mv_en = 1; mv_mask = 8'h01; mv_word = 32'h0000_0006;
        cp_en = 1; cp_src = 0; cp_dst = 7; tick();
        exp_cr = put(exp_cr, 7, 4'h6);
        check("R9 move over copy", cr_value, exp_cr);
        cp_en = 1; cp_src = 7; cp_dst = 2; xl_en = 1; xl_dst = 2; xer_top = 4'h9; tick();
        exp_cr = put(exp_cr, 2, 4'h6);
        check("R9 copy over xer", cr_value, exp_cr);
        xl_en = 1; xl_dst = 1; xer_top = 4'h3; cmp_en = 1; cmp_dst = 1; cmp_code = 4'hC; tick();
        exp_cr = put(exp_cr, 1, 4'h3);
        check("R9 xer over cmp", cr_value, exp_cr);
        cmp_en = 1; cmp_dst = 0; cmp_code = 4'hA; rec_en = 1; rec_res = 64'h0;
        mode64 = 1; xer_top = 4'h0; tick();
        exp_cr = put(exp_cr, 0, 4'hA);
        check("R9 cmp over rec", cr_value, exp_cr);
    endtask

    task automatic t_branch();
        mv_en = 1; mv_mask = 8'hFF; mv_word = 32'h1357_9BDF; tick();
        exp_cr = 32'h1357_9BDF;
        for (int k = 0; k < 8; k++) begin
            br_idx = 3'(k); #1;
            if (k < 4) begin
                check("R10 fld", {28'h0, br_fld}, {28'h0, exp_cr[31-4*k -: 4]});
                check("R10 err lo", {31'h0, br_err}, 32'h0);
            end else begin
                check("R10 illegal fld", {28'h0, br_fld}, 32'h0);
                check("R10 err hi", {31'h0, br_err}, 32'h1);
            end
        end
    endtask

    task automatic t_hold();
        for (int n = 0; n < 4; n++) begin
            tick();
            check("R11 hold", cr_value, exp_cr);
        end
    endtask

    initial begin
        #1;
        t_reset();
        t_record();
        t_move();
        t_copy();
        t_xer_cmp();
        t_prio();
        t_branch();
        t_hold();
        t_reset();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule